// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a set of interrupt inputs, each either level-sensitive (active high) or edge-sensitive (rising edge, latched), and presents the most urgent one to a processor as a vector. Every source has a programmable 3-bit priority and a vector word. Source 0 is the fast source: it drives the fast interrupt line on its own and takes no part in vector arbitration. Sources 1 and up compete for the normal interrupt line.

Software reads the vector register to claim an interrupt. The read returns the vector of the highest-priority pending enabled source above the level now being serviced. It records that source and, in normal mode, pushes that source's priority onto an 8-deep level stack and acknowledges the source. A write to the end-of-interrupt register pops one level. In protect mode the read has no side effects, so a debugger can inspect the register safely. The push and acknowledge then happen on a write to the vector register. When nothing qualifies at the time of the read, the programmed spurious vector is returned. A global mask holds both interrupt lines inactive, but the wakeup output keeps reporting pending enabled sources.

Top module: `vpic`

## Requirements
- R1: After reset both `n_irq` and `n_fiq` are high, `wake` is low, all sources are disabled, and a read of the vector register (byte address 0x100) returns the spurious vector register (0x114), which resets to 0.
- R2: Among pending enabled sources 1..NSRC-1, the one with the highest priority (config register 0x000+4*i, bits [2:0], 7 highest) wins, and ties go to the lowest source number. A vector read returns the winner's vector register (0x080+4*i).
- R3: `n_irq` is low only when the winner's priority is strictly above the top of the level stack, or the stack is empty.
- R4: In normal mode a vector read that finds a winner pushes its priority and acknowledges it. Acknowledging clears an edge source's latch. A level source stays pending while its input is high.
- R5: When protect mode is on (0x118 bit 0), a vector read neither pushes nor acknowledges. A write to 0x100 then pushes and acknowledges the source found by the last read. In normal mode a write to 0x100 has no effect.
- R6: A vector read with no qualifying source returns the spurious vector and pushes nothing.
- R7: A write to the end-of-interrupt register (0x104) pops one level. A pop on an empty stack is ignored. The stack never holds more than 8 levels.
- R8: When the global mask is set (0x118 bit 1), `n_irq` and `n_fiq` stay high, while `wake` still goes high for any pending enabled source.
- R9: Source 0 drives `n_fiq` low when it is pending and enabled. It is never returned by a vector read.
- R10: Writing ones to 0x108 enables sources and writing ones to 0x10C disables them. Writing ones to 0x110 clears edge latches.
- R11: An edge source (config bit 4 = 1) latches a rising edge of its input and stays pending after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Interrupt source inputs |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| n_irq | output | 1 | Normal interrupt request, active low |
| n_fiq | output | 1 | Fast interrupt request, active low |
| wake | output | 1 | Wakeup request, not gated by the global mask |

## Verification
The bench drives equal priorities on two sources and expects the lower number to win. A reversed scan would return the wrong vector. It nests a higher-priority source over a lower one, then pops past an empty stack. A stack that underflowed would then hide the lower source or return a stale level. Edge pulses are checked across read, acknowledge and end-of-interrupt, so a design that failed to clear the latch would assert the request again instead of giving the spurious vector. Protect mode is exercised by reading the vector twice without a state change, then writing it. The global mask is checked to silence both lines while the wakeup output stays active.

// File: rtl/vpic.sv
module vpic #(
  parameter int NSRC  = 8,
  parameter int PW    = 3,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [8:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             n_irq,
  output logic             n_fiq,
  output logic             wake
);
  localparam int IW  = $clog2(NSRC);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [PW-1:0]   prio [NSRC];
  logic [31:0]     vec  [NSRC];
  logic [PW-1:0]   stk  [DEPTH];
  logic [NSRC-1:0] edge_mode, enab, latch, src_q;
  logic [31:0]     spu;
  logic            prot, gmsk, cur_ok;
  logic [IW-1:0]   cur;
  logic [SPW-1:0]  sp;

  wire [4:0] idx    = bus_addr[6:2];
  wire       cfg_a  = bus_addr[8:7] == 2'b00;
  wire       vec_a  = bus_addr[8:7] == 2'b01;
  wire       ctl_a  = bus_addr[8:7] == 2'b10;
  wire       wr     = bus_sel & bus_wr;
  wire       rd_vec = bus_sel & ~bus_wr & ctl_a & (idx == 5'd0);
  wire       wr_vec = wr & ctl_a & (idx == 5'd0);
  wire       wr_eoi = wr & ctl_a & (idx == 5'd1);
  wire       wr_en  = wr & ctl_a & (idx == 5'd2);
  wire       wr_dis = wr & ctl_a & (idx == 5'd3);
  wire       wr_clr = wr & ctl_a & (idx == 5'd4);
  wire       wr_spu = wr & ctl_a & (idx == 5'd5);
  wire       wr_dbg = wr & ctl_a & (idx == 5'd6);

  wire [NSRC-1:0] pend = (edge_mode & latch) | (~edge_mode & src_in);
  wire [NSRC-1:0] act  = pend & enab;

  logic          win_ok;
  logic [IW-1:0] win;
  logic [PW-1:0] win_p, top;
  always_comb begin
    win_ok = 1'b0; win = '0; win_p = '0;
    for (int i = NSRC - 1; i >= 1; i--)
      if (act[i] && (!win_ok || prio[i] >= win_p)) begin
        win_ok = 1'b1; win = IW'(i); win_p = prio[i];
      end
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (SPW'(i + 1) == sp) top = stk[i];
  end

  wire above = win_ok && (sp == '0 || win_p > top);

  wire           push_n  = rd_vec & ~prot & above;
  wire           push_p  = wr_vec & prot & cur_ok;
  wire           do_push = (push_n | push_p) && sp < SPW'(DEPTH);
  wire [IW-1:0]  ack_src = push_n ? win : cur;
  wire [NSRC-1:0] clr_mask = (wr_clr ? bus_wdata[NSRC-1:0] : '0)
                           | (do_push ? (NSRC'(1) << ack_src) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin prio[i] <= '0; vec[i] <= '0; end
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
      edge_mode <= '0; enab <= '0; latch <= '0; src_q <= '0;
      spu <= '0; prot <= 1'b0; gmsk <= 1'b0;
      cur_ok <= 1'b0; cur <= '0; sp <= '0;
    end else begin
      src_q <= src_in;
      latch <= (latch & ~clr_mask) | (src_in & ~src_q & edge_mode);
      for (int i = 0; i < NSRC; i++) begin
        if (wr && cfg_a && idx == 5'(i)) begin
          prio[i]      <= bus_wdata[PW-1:0];
          edge_mode[i] <= bus_wdata[4];
        end
        if (wr && vec_a && idx == 5'(i)) vec[i] <= bus_wdata;
      end
      if (wr_en)  enab <= enab | bus_wdata[NSRC-1:0];
      if (wr_dis) enab <= enab & ~bus_wdata[NSRC-1:0];
      if (wr_spu) spu <= bus_wdata;
      if (wr_dbg) begin prot <= bus_wdata[0]; gmsk <= bus_wdata[1]; end
      if (rd_vec) begin cur <= win; cur_ok <= above; end
      else if (push_p) cur_ok <= 1'b0;
      if (do_push) begin
        for (int i = 0; i < DEPTH; i++)
          if (SPW'(i) == sp) stk[i] <= push_n ? win_p : prio[cur];
        sp <= sp + SPW'(1);
      end else if (wr_eoi && sp != '0) begin
        sp <= sp - SPW'(1);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (cfg_a && idx < 5'(NSRC))
      bus_rdata = (32'(edge_mode[idx[IW-1:0]]) << 4) | 32'(prio[idx[IW-1:0]]);
    else if (vec_a && idx < 5'(NSRC))
      bus_rdata = vec[idx[IW-1:0]];
    else if (ctl_a)
      case (idx)
        5'd0:    bus_rdata = above ? vec[win] : spu;
        5'd2:    bus_rdata = 32'(enab);
        5'd5:    bus_rdata = spu;
        5'd6:    bus_rdata = {30'd0, gmsk, prot};
        default: bus_rdata = '0;
      endcase
  end

  assign n_irq = ~(above & ~gmsk);
  assign n_fiq = ~(act[0] & ~gmsk);
  assign wake  = |act;

  assert_mask_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gmsk |-> (n_irq && n_fiq));
  assert_stack_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && sp == '0) |=> sp == '0);
  assert_read_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !prot && above && sp < SPW'(DEPTH)) |=> sp == $past(sp) + SPW'(1));
  assert_protect_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && prot) |=> $stable(sp));
  assert_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !win_ok) |-> bus_rdata == spu);
endmodule

// File: tb/vpic_test.sv
module vpic_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  src_in = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        n_irq, n_fiq, wake;
  int checks = 0, fails = 0;
  logic [31:0] d;

  vpic uut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
            .n_irq(n_irq), .n_fiq(n_fiq), .wake(wake));

  always #4 clk = ~clk;

  localparam logic [31:0] SPU = 32'hDEAD;
  function automatic logic [31:0] vv(int i); return 32'h1000 + i * 16; endfunction

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, a, e); end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1 v = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic pulse(int i);
    @(negedge clk); src_in[i] = 1; @(negedge clk); src_in[i] = 0; #1;
  endtask

  task automatic t_reset;
    chk("R1 n_irq", n_irq, 1); chk("R1 n_fiq", n_fiq, 1); chk("R1 wake", wake, 0);
    rd(9'h100, d); chk("R1 vector", d, 0);
  endtask

  task automatic t_arbitration;
    wr(9'h008, 3); wr(9'h014, 5); wr(9'h018, 5);
    @(negedge clk); src_in[2] = 1; src_in[5] = 1; src_in[6] = 1; #1;
    chk("R3 n_irq low", n_irq, 0);
    rd(9'h100, d); chk("R2 tie lowest", d, vv(5));
    chk("R3 equal level blocked", n_irq, 1);
    wr(9'h104, 0); chk("R7 pop", n_irq, 0);
    rd(9'h100, d); chk("R4 level stays pending", d, vv(5));
    wr(9'h104, 0);
    @(negedge clk); src_in = '0; #1;
  endtask

  task automatic t_nesting;
    @(negedge clk); src_in[2] = 1; #1;
    rd(9'h100, d); chk("R2 single", d, vv(2));
    chk("R3 same source blocked", n_irq, 1);
    @(negedge clk); src_in[4] = 1; wr(9'h010, 6);
    chk("R3 higher nests", n_irq, 0);
    rd(9'h100, d); chk("R2 nested", d, vv(4));
    @(negedge clk); src_in[4] = 0; #1;
    wr(9'h104, 0); wr(9'h104, 0); wr(9'h104, 0);
    chk("R7 empty pop ignored", n_irq, 0);
    rd(9'h100, d); chk("R7 stack intact", d, vv(2));
    wr(9'h104, 0);
    @(negedge clk); src_in[2] = 0; #1;
  endtask

  task automatic t_edge;
    wr(9'h00C, 32'h12);
    pulse(3); chk("R11 edge latched", n_irq, 0);
    rd(9'h100, d); chk("R11 edge vector", d, vv(3));
    wr(9'h104, 0); chk("R4 ack cleared latch", n_irq, 1);
    rd(9'h100, d); chk("R6 spurious after ack", d, SPU);
    wr(9'h104, 0);
  endtask

  task automatic t_protect;
    wr(9'h118, 1); pulse(3);
    rd(9'h100, d); chk("R5 protect read", d, vv(3));
    rd(9'h100, d); chk("R5 no side effect", d, vv(3));
    chk("R5 still requesting", n_irq, 0);
    wr(9'h100, 0); chk("R5 write pushes", n_irq, 1);
    wr(9'h104, 0); chk("R5 write acked", n_irq, 1);
    wr(9'h118, 0); pulse(3);
    wr(9'h100, 0); chk("R5 normal write no effect", n_irq, 0);
    rd(9'h100, d); chk("R5 normal read after write", d, vv(3));
    wr(9'h104, 0);
  endtask

  task automatic t_spurious;
    @(negedge clk); src_in[2] = 1; #1; chk("R6 request", n_irq, 0);
    @(negedge clk); src_in[2] = 0; #1;
    rd(9'h100, d); chk("R6 spurious vector", d, SPU);
    @(negedge clk); src_in[2] = 1; #1; chk("R6 no push", n_irq, 0);
    @(negedge clk); src_in[2] = 0; #1;
  endtask

  task automatic t_gmask;
    @(negedge clk); src_in[0] = 1; #1;
    chk("R9 fiq", n_fiq, 0); chk("R9 no irq", n_irq, 1);
    rd(9'h100, d); chk("R9 not vectored", d, SPU);
    @(negedge clk); src_in[2] = 1; #1;
    wr(9'h118, 2);
    chk("R8 irq masked", n_irq, 1); chk("R8 fiq masked", n_fiq, 1); chk("R8 wake", wake, 1);
    wr(9'h118, 0); chk("R8 unmasked", n_fiq, 0);
    @(negedge clk); src_in = '0; #1;
  endtask

  task automatic t_enable;
    @(negedge clk); src_in[2] = 1; #1;
    wr(9'h10C, 32'h4); chk("R10 disabled", n_irq, 1); chk("R10 wake off", wake, 0);
    wr(9'h108, 32'h4); chk("R10 enabled", n_irq, 0);
    @(negedge clk); src_in[2] = 0; #1;
    pulse(3); chk("R10 latched", n_irq, 0);
    wr(9'h110, 32'h8); chk("R10 clear", n_irq, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    for (int i = 0; i < 8; i++) wr(9'(9'h080 + 4 * i), vv(i));
    wr(9'h114, SPU); wr(9'h108, 32'hFF);
    t_arbitration; t_nesting; t_edge; t_protect; t_spurious; t_gmask; t_enable;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule